// File: doc/BRIEF.md
# Interrupt Flag, Periodic Tick and Power-Off Detect Unit

This block is a byte-wide register window for a peripheral controller. It keeps a set of pending interrupt flags, an enable mask for them, and combines the enabled, pending flags into one interrupt line for the processor. Two flags are set by free-running tick generators clocked from the system clock. One is a display-refresh tick with a period of about 16.63 ms. The other is a whole-second tick. These tick flags are set whether or not their enables are on, so software polling the flag register still sees them. The other flags follow level-style external interrupt inputs.

The window decodes sixteen byte registers from address bits [12:9], so the registers sit 0x200 bytes apart inside an 0x2000-byte window. Only four registers are implemented: an output data port, its direction register, the flag register and the enable register. A write that drives the power-control bit of the output port low, while that bit is set as an output, raises a one-cycle power-off request.

Top module: `periph_irq_tick`

## Requirements
- R1: After a synchronous reset, the pending flags, the enable mask, the output port data and the output port direction are all zero. `irq_out`, `pwr_off_req` and `bus_rdata` are also zero.
- R2: The register index is `bus_addr[12:9]`, and address bits [8:0] are ignored. Index 0 is the output port data, index 2 is the port direction, index 13 is the flag register and index 14 is the enable register. Any other index reads 0x00, and writes to it have no effect.
- R3: A read (`bus_sel`=1, `bus_we`=0) presents the selected register on `bus_rdata` from the next clock edge. The value reflects the state before that edge, and `bus_rdata` holds its value until the next read.
- R4: Writing the enable register with data bit 7 = 1 sets the enable bits where data bits [6:0] are 1. With bit 7 = 0 it clears those bits. Reading the enable register returns bit 7 as 1 and bits [6:0] as the mask.
- R5: Writing a 1 to a bit in [6:0] of the flag register clears that pending flag. Writing a 0 leaves it unchanged, and bit 7 of the write data is ignored.
- R6: External input `ext_irq[k]` drives flag bit k+2. A 0-to-1 change of the input between two clock edges sets the flag, and a 1-to-0 change clears it. While the input is steady, the flag changes only through writes.
- R7: The refresh tick sets flag bit 1 once every VBL_US microseconds of system clock, whatever the enable mask holds. The first tick comes that many cycles after reset.
- R8: The second tick sets flag bit 0 once every SEC_US microseconds of system clock, whatever the enable mask holds. Its period is aligned to reset.
- R9: Flag register bit 7 reads as 1 exactly when (flags AND enables) is non-zero. `irq_out` shows the same condition one clock later.
- R10: Writing the port data register with bit 2 = 0, while direction bit 2 is 1, pulses `pwr_off_req` high for one cycle after the write edge. No other write raises it.
- R11: When a set event (a tick or a rising input) and a write-1 clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Byte access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address inside the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_irq | input | 5 | Level interrupt inputs, mapped to flag bits 2 to 6 |
| irq_out | output | 1 | Registered combined interrupt request |
| pwr_off_req | output | 1 | One-cycle power-off request |
| portb_out | output | 8 | Output port data register |
| portb_dir | output | 8 | Output port direction register (1 = output) |

## Verification
A wrong tick counter shows up as a refresh or second flag that appears a cycle early or late in the next flag read, or a cycle off on `irq_out` once the matching enable is on. A corrupted flag or enable bit reaches `irq_out` within one clock whenever the other operand is set. Otherwise it shows on the next read of the flag or enable register, one cycle after the read strobe. A wrong edge detector on the external inputs shows as a flag that is cleared by a write but reappears without a new input edge, or that misses a falling input. A wrong power-off condition shows on `pwr_off_req` in the cycle right after the port write.

// File: rtl/periph_irq_pkg.sv
package periph_irq_pkg;
  localparam int unsigned IDX_W      = 4;
  localparam int unsigned FLAG_W     = 7;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned N_TICK     = 2;

  localparam logic [IDX_W-1:0] IDX_PORT_DATA = 4'd0;
  localparam logic [IDX_W-1:0] IDX_PORT_DIR  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_FLAG      = 4'd13;
  localparam logic [IDX_W-1:0] IDX_ENABLE    = 4'd14;

  localparam int unsigned FBIT_SEC    = 0;
  localparam int unsigned FBIT_VBL    = 1;
  localparam int unsigned FBIT_EXT_LO = 2;

  typedef struct packed {
    logic             rd;
    logic             wr;
    logic [IDX_W-1:0] idx;
  } bus_req_t;
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import periph_irq_pkg::*;
#(
  parameter int unsigned N_EXT = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_flag,
  input  logic                  wr_enable,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [N_TICK-1:0]     tick_vec,
  input  logic [N_EXT-1:0]      ext_irq,
  output logic [FLAG_W-1:0]     flag_q,
  output logic [FLAG_W-1:0]     en_q,
  output logic                  any_pend,
  output logic                  irq_q
);
  logic [N_EXT-1:0]  ext_q;
  logic [N_EXT-1:0]  rise, fall;
  logic [FLAG_W-1:0] set_vec, drop_vec, wclr_vec, flag_d, en_d;

  assign rise = ext_irq & ~ext_q;
  assign fall = ~ext_irq & ext_q;

  always_comb begin
    set_vec  = '0;
    drop_vec = '0;
    for (int t = 0; t < N_TICK; t++) begin
      set_vec[t] = tick_vec[t];
    end
    for (int i = 0; i < N_EXT; i++) begin
      set_vec[FBIT_EXT_LO+i]  = rise[i];
      drop_vec[FBIT_EXT_LO+i] = fall[i];
    end
  end

  assign wclr_vec = wr_flag ? wdata[FLAG_W-1:0] : '0;
  assign flag_d   = (flag_q & ~wclr_vec & ~drop_vec) | set_vec;

  always_comb begin
    en_d = en_q;
    if (wr_enable) begin
      if (wdata[DATA_W-1]) en_d = en_q | wdata[FLAG_W-1:0];
      else                 en_d = en_q & ~wdata[FLAG_W-1:0];
    end
  end

  assign any_pend = |(flag_q & en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q  <= '0;
      flag_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      ext_q  <= ext_irq;
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_q  <= any_pend;
    end
  end

  p_tick_sec_r8: assert property (@(posedge clk) disable iff (rst)
    tick_vec[FBIT_SEC] |=> flag_q[FBIT_SEC]);
  p_tick_vbl_r7: assert property (@(posedge clk) disable iff (rst)
    tick_vec[FBIT_VBL] |=> flag_q[FBIT_VBL]);
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(en_q) != '0));
endmodule

// File: rtl/port_unit.sv
module port_unit
  import periph_irq_pkg::*;
#(
  parameter int unsigned PWR_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic              wr_dir,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] dir_q,
  output logic              pwr_req_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      dir_q     <= '0;
      pwr_req_q <= 1'b0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
      pwr_req_q <= wr_data && dir_q[PWR_BIT] && !wdata[PWR_BIT];
    end
  end

  p_pwr_dir_r10: assert property (@(posedge clk) disable iff (rst)
    pwr_req_q |-> dir_q[PWR_BIT]);
  p_pwr_low_r10: assert property (@(posedge clk) disable iff (rst)
    pwr_req_q |-> !data_q[PWR_BIT]);
endmodule

// File: rtl/periph_irq_tick.sv
module periph_irq_tick
  import periph_irq_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int unsigned VBL_US  = 16_630,
  parameter int unsigned SEC_US  = 1_000_000,
  parameter int unsigned N_EXT   = 5,
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned SEL_LSB = 9,
  parameter int unsigned PWR_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [N_EXT-1:0]  ext_irq,
  output logic              irq_out,
  output logic              pwr_off_req,
  output logic [7:0]        portb_out,
  output logic [7:0]        portb_dir
);
  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned SEC_CYC    = CYC_PER_US * SEC_US;
  localparam int unsigned VBL_CYC    = CYC_PER_US * VBL_US;

  bus_req_t          req;
  logic [N_TICK-1:0] tick_vec;
  logic [FLAG_W-1:0] flag_q, en_q;
  logic              any_pend;
  logic [7:0]        rd_mux, rdata_q;
  logic              unused_addr_bits;

  assign req.rd  = bus_sel && !bus_we;
  assign req.wr  = bus_sel && bus_we;
  assign req.idx = bus_addr[SEL_LSB +: IDX_W];
  assign unused_addr_bits = ^bus_addr[SEL_LSB-1:0];

  for (genvar t = 0; t < N_TICK; t++) begin : g_tick
    tick_gen #(
      .PERIOD((t == FBIT_SEC) ? SEC_CYC : VBL_CYC)
    ) u_tick (
      .clk (clk),
      .rst (rst),
      .tick(tick_vec[t])
    );
  end

  flag_unit #(.N_EXT(N_EXT)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .wr_flag  (req.wr && req.idx == IDX_FLAG),
    .wr_enable(req.wr && req.idx == IDX_ENABLE),
    .wdata    (bus_wdata),
    .tick_vec (tick_vec),
    .ext_irq  (ext_irq),
    .flag_q   (flag_q),
    .en_q     (en_q),
    .any_pend (any_pend),
    .irq_q    (irq_out)
  );

  port_unit #(.PWR_BIT(PWR_BIT)) u_port (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (req.wr && req.idx == IDX_PORT_DATA),
    .wr_dir   (req.wr && req.idx == IDX_PORT_DIR),
    .wdata    (bus_wdata),
    .data_q   (portb_out),
    .dir_q    (portb_dir),
    .pwr_req_q(pwr_off_req)
  );

  always_comb begin
    case (req.idx)
      IDX_PORT_DATA: rd_mux = portb_out;
      IDX_PORT_DIR:  rd_mux = portb_dir;
      IDX_FLAG:      rd_mux = {any_pend, flag_q};
      IDX_ENABLE:    rd_mux = {1'b1, en_q};
      default:       rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= 8'h00;
    else if (req.rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  p_en_read_r4: assert property (@(posedge clk) disable iff (rst)
    (req.rd && req.idx == IDX_ENABLE) |=> bus_rdata[7]);
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (req.rd && req.idx != IDX_PORT_DATA && req.idx != IDX_PORT_DIR &&
     req.idx != IDX_FLAG && req.idx != IDX_ENABLE) |=> (bus_rdata == 8'h00));
endmodule

// File: tb/test_periph_irq_tick.sv
`timescale 1ns/1ps
module test_periph_irq_tick;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [4:0]  ext_irq = '0;
  logic [7:0]  bus_rdata, portb_out, portb_dir;
  logic        irq_out, pwr_off_req;

  always #4 clk = ~clk;

  periph_irq_tick #(.CLK_HZ(1_000_000), .VBL_US(300), .SEC_US(1000)) i_periph_irq_tick (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_irq(ext_irq), .irq_out(irq_out),
    .pwr_off_req(pwr_off_req), .portb_out(portb_out), .portb_dir(portb_dir));

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference
  logic [6:0] m_flag, m_en;
  logic [7:0] m_data, m_dir, m_rdata;
  logic [4:0] m_ext_prev;
  logic       m_irq, m_pwr;
  int         m_vcnt, m_scnt;

  always @(posedge clk) begin
    logic [3:0] idx;
    logic [7:0] rv;
    logic [6:0] setv, dropv, clrv;
    if (rst) begin
      m_flag = 0; m_en = 0; m_data = 0; m_dir = 0; m_rdata = 0;
      m_ext_prev = 0; m_irq = 0; m_pwr = 0; m_vcnt = 0; m_scnt = 0;
    end else begin
      idx = bus_addr[12:9];
      case (idx)
        4'd0:  rv = m_data;
        4'd2:  rv = m_dir;
        4'd13: rv = {(m_flag & m_en) != 0, m_flag};
        4'd14: rv = {1'b1, m_en};
        default: rv = 8'h00;
      endcase
      if (bus_sel && !bus_we) m_rdata = rv;
      m_irq = (m_flag & m_en) != 0;
      m_pwr = bus_sel && bus_we && idx == 0 && m_dir[2] && !bus_wdata[2];
      setv = 0; dropv = 0;
      if (m_scnt == 999) setv[0] = 1;
      if (m_vcnt == 299) setv[1] = 1;
      for (int k = 0; k < 5; k++) begin
        if (ext_irq[k] && !m_ext_prev[k]) setv[k+2] = 1;
        if (!ext_irq[k] && m_ext_prev[k]) dropv[k+2] = 1;
      end
      clrv = (bus_sel && bus_we && idx == 13) ? bus_wdata[6:0] : 7'h0;
      m_flag = (m_flag & ~clrv & ~dropv) | setv;
      if (bus_sel && bus_we && idx == 14)
        m_en = bus_wdata[7] ? (m_en | bus_wdata[6:0]) : (m_en & ~bus_wdata[6:0]);
      if (bus_sel && bus_we && idx == 0) m_data = bus_wdata;
      if (bus_sel && bus_we && idx == 2) m_dir = bus_wdata;
      m_ext_prev = ext_irq;
      m_scnt = (m_scnt == 999) ? 0 : m_scnt + 1;
      m_vcnt = (m_vcnt == 299) ? 0 : m_vcnt + 1;
    end
  end

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk("rdata", bus_rdata, m_rdata);
      chk("irq_out", {7'h0, irq_out}, {7'h0, m_irq});
      chk("pwr_off_req", {7'h0, pwr_off_req}, {7'h0, m_pwr});
      chk("portb_out", portb_out, m_data);
      chk("portb_dir", portb_dir, m_dir);
    end
  end

  task automatic bw(input logic [3:0] idx, input logic [8:0] low, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = {idx, low}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic br(input logic [3:0] idx, input logic [8:0] low);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = {idx, low};
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1: actual hung expected finished");
    finish_run();
  end

  initial begin
    phase = "R1";
    repeat (4) @(negedge clk);
    rst = 0;
    br(4'd13, 0); br(4'd14, 0); br(4'd0, 0); br(4'd2, 0);
    phase = "R4";
    bw(4'd14, 0, 8'h86); br(4'd14, 0);
    bw(4'd14, 0, 8'h02); br(4'd14, 0);
    bw(4'd14, 0, 8'h04); br(4'd14, 0);
    phase = "R6";
    @(negedge clk) ext_irq = 5'b00001; idle(2); br(4'd13, 0);
    @(negedge clk) ext_irq = 5'b10001; idle(2); br(4'd13, 0);
    @(negedge clk) ext_irq = 5'b00001; idle(2); br(4'd13, 0);
    phase = "R5";
    bw(4'd13, 0, 8'h04); br(4'd13, 0); idle(3); br(4'd13, 0);
    bw(4'd13, 0, 8'h80); br(4'd13, 0);
    phase = "R11";
    @(negedge clk);
    ext_irq = 5'b00011; bus_sel = 1; bus_we = 1; bus_addr = {4'd13, 9'd0}; bus_wdata = 8'h08;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    br(4'd13, 0);
    phase = "R9";
    bw(4'd14, 0, 8'h88); idle(2); br(4'd13, 0);
    bw(4'd13, 0, 8'h0C); idle(2); br(4'd13, 0);
    phase = "R7";
    bw(4'd14, 0, 8'h7F); idle(320); br(4'd13, 0);
    phase = "R8";
    idle(700); br(4'd13, 0);
    phase = "R9";
    bw(4'd14, 0, 8'h81); idle(300); br(4'd13, 0);
    bw(4'd13, 0, 8'h7F); idle(2);
    phase = "R2";
    bw(4'd14, 9'h1A5, 8'h83); br(4'd14, 9'h0FF);
    bw(4'd5, 0, 8'hFF); br(4'd5, 0); br(4'd15, 9'h001);
    bw(4'd0, 9'h1FF, 8'hA5); br(4'd0, 9'h003);
    phase = "R3";
    br(4'd2, 0); idle(4);
    phase = "R10";
    bw(4'd2, 0, 8'h04); bw(4'd0, 0, 8'h00); idle(2);
    bw(4'd0, 0, 8'h04); idle(2);
    bw(4'd0, 0, 8'hFB); idle(2);
    bw(4'd2, 0, 8'hFB); bw(4'd0, 0, 8'h00); idle(2);
    phase = "R7";
    idle(1200); br(4'd13, 0);
    finish_run();
  end
endmodule